// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide, two-address register front end of an eight-line programmable interrupt controller. Software writes a short initialization sequence to set the vector base and the operating mode. After that it writes the mask register and sends command bytes that end interrupts, rotate priorities, pick which register a read returns, enable special mask mode or arm a poll. The block holds the in-service and mask registers, the rotation offset, the vector base and the mode flags, and drives them out to the rest of the controller.

The pending-request vector and the current winning line come from neighbouring blocks. The edge/level front end supplies `pend_i`, and an external priority resolver supplies `win_valid_i`/`win_line_i`. A poll read returns the winner and acknowledges it. The block then pulses `ack_o` with the line number so that the front end can drop the pending bit. For non-specific end-of-interrupt, the block picks the highest-priority in-service line itself: priority falls with distance from `offset_o`, starting at `offset_o` itself. If a write and a read arrive in the same cycle, the write is taken and the read is dropped.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with bit 4 set clears the in-service register, mask, offset, vector base, read select, poll, special mask, auto-EOI, rotate-on-auto-EOI and nested flags. It records a fourth-word flag from bit 0 and a single-mode flag from bit 1, and arms the second initialization word.
- R2: The next address-1 write sets the vector base to data AND 0xF8. After that, the sequence expects a third word (not single mode), a fourth word (single mode with the bit-0 flag set), or it ends (single mode without that flag). A third word is swallowed, and the sequence then moves to the fourth word or ends, according to the bit-0 flag.
- R3: An address-1 write loads the mask only when no initialization is in progress. During initialization it leaves the mask unchanged.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command. If bit 1 is set, bit 0 selects the in-service register (1) or the pending vector (0) for later address-0 reads. If bit 2 is set, a poll is armed.
- R5: In that read/poll command, bit 6 set copies bit 5 into the special mask flag. Bit 6 clear leaves the flag as it was.
- R6: A write to address 0 with bits 4 and 3 clear carries a command in bits 7:5. Commands 0 and 4 set rotate-on-auto-EOI to 0 and 1.
- R7: Commands 1 and 5 clear the highest-priority in-service bit, if there is one. Command 5 also sets the offset to that line plus 1, modulo 8.
- R8: Command 3 clears in-service bit data[2:0]. Command 6 sets the offset to data[2:0]+1. Command 7 does both for line data[2:0]. Command 2 changes nothing.
- R9: A read after a poll returns 0x80 OR the winning line and pulses `ack_o` with that line for one cycle. With no winner it returns 0 and does not acknowledge. Either way the poll is disarmed.
- R10: The poll acknowledge sets the line's in-service bit when auto-EOI is off. When auto-EOI is on, it leaves the in-service bit clear, and with rotate-on-auto-EOI set it moves the offset to that line plus 1.
- R11: The fourth initialization word sets auto-EOI from bit 1 and nested mode from bit 4, then ends the sequence.
- R12: With no poll armed, an address-1 read returns the mask and an address-0 read returns the register picked by R4. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register address bit |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| pend_i | input | 8 | Pending request vector from the front end |
| win_valid_i | input | 1 | Resolver has a winning line |
| win_line_i | input | 3 | Winning line number |
| rd_data_o | output | 8 | Read data, registered |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| offset_o | output | 3 | Rotation offset (highest-priority line) |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| aeoi_o | output | 1 | Automatic EOI mode |
| rot_aeoi_o | output | 1 | Rotate on automatic EOI |
| spec_mask_o | output | 1 | Special mask mode |
| nested_o | output | 1 | Special fully nested mode |
| ack_o | output | 1 | Poll acknowledge pulse |
| ack_line_o | output | 3 | Acknowledged line |

## Verification
Every state output and `rd_data_o` updates at the first rising edge that samples the strobe, and the bench checks them at the falling edge that follows. `ack_o` is valid for exactly that one cycle. The bench drives every stimulus at a falling edge. It moves a reference model one step per cycle and compares all outputs half a period after the edge, so every result is checked in the cycle it is due and no earlier.

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  input  logic [LINES-1:0] pend_i,
  input  logic             win_valid_i,
  input  logic [2:0]       win_line_i,
  output logic [7:0]       rd_data_o,
  output logic [LINES-1:0] isr_o,
  output logic [LINES-1:0] imr_o,
  output logic [2:0]       offset_o,
  output logic [7:0]       vec_base_o,
  output logic             aeoi_o,
  output logic             rot_aeoi_o,
  output logic             spec_mask_o,
  output logic             nested_o,
  output logic             ack_o,
  output logic [2:0]       ack_line_o
);
  localparam int LW = $clog2(LINES);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BASE = 2'd1, ST_CASC = 2'd2, ST_MODE = 2'd3;

  logic [1:0]       init_st;
  logic             need4_q, single_q, rsel_q, poll_q;
  logic [LINES-1:0] isr_q, imr_q;
  logic [LW-1:0]    off_q;
  logic [4:0]       base_q;
  logic             aeoi_q, rot_q, smm_q, nest_q;
  logic [7:0]       rd_q;
  logic             ack_q;
  logic [2:0]       ack_line_q;

  wire       wr_low  = wr_en_i && !addr_i;
  wire       wr_high = wr_en_i && addr_i;
  wire       is_init = wr_low && wr_data_i[4];
  wire       is_sel  = wr_low && !wr_data_i[4] && wr_data_i[3];
  wire       is_cmd  = wr_low && !wr_data_i[4] && !wr_data_i[3];
  wire [2:0] cmd     = wr_data_i[7:5];
  wire [LW-1:0] sel_line = wr_data_i[LW-1:0];

  logic          top_hit;
  logic [LW-1:0] top_line;

  always_comb begin
    top_hit  = 1'b0;
    top_line = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      logic [LW-1:0] k;
      k = off_q + LW'(p);
      if (isr_q[k]) begin
        top_hit  = 1'b1;
        top_line = k;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_st    <= ST_IDLE;
      need4_q    <= 1'b0;
      single_q   <= 1'b0;
      rsel_q     <= 1'b0;
      poll_q     <= 1'b0;
      isr_q      <= '0;
      imr_q      <= '0;
      off_q      <= '0;
      base_q     <= '0;
      aeoi_q     <= 1'b0;
      rot_q      <= 1'b0;
      smm_q      <= 1'b0;
      nest_q     <= 1'b0;
      rd_q       <= '0;
      ack_q      <= 1'b0;
      ack_line_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (is_init) begin
        init_st  <= ST_BASE;
        need4_q  <= wr_data_i[0];
        single_q <= wr_data_i[1];
        rsel_q   <= 1'b0;
        poll_q   <= 1'b0;
        isr_q    <= '0;
        imr_q    <= '0;
        off_q    <= '0;
        base_q   <= '0;
        aeoi_q   <= 1'b0;
        rot_q    <= 1'b0;
        smm_q    <= 1'b0;
        nest_q   <= 1'b0;
      end else if (is_sel) begin
        if (wr_data_i[2]) poll_q <= 1'b1;
        if (wr_data_i[1]) rsel_q <= wr_data_i[0];
        if (wr_data_i[6]) smm_q  <= wr_data_i[5];
      end else if (is_cmd) begin
        case (cmd)
          3'd0, 3'd4: rot_q <= cmd[2];
          3'd1, 3'd5: if (top_hit) begin
            isr_q[top_line] <= 1'b0;
            if (cmd[2]) off_q <= top_line + 1'b1;
          end
          3'd3: isr_q[sel_line] <= 1'b0;
          3'd6: off_q <= sel_line + 1'b1;
          3'd7: begin
            isr_q[sel_line] <= 1'b0;
            off_q <= sel_line + 1'b1;
          end
          default: ;
        endcase
      end else if (wr_high) begin
        case (init_st)
          ST_IDLE: imr_q <= wr_data_i[LINES-1:0];
          ST_BASE: begin
            base_q  <= wr_data_i[7:3];
            init_st <= !single_q ? ST_CASC : (need4_q ? ST_MODE : ST_IDLE);
          end
          ST_CASC: init_st <= need4_q ? ST_MODE : ST_IDLE;
          default: begin
            aeoi_q  <= wr_data_i[1];
            nest_q  <= wr_data_i[4];
            init_st <= ST_IDLE;
          end
        endcase
      end else if (rd_en_i) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (win_valid_i) begin
            rd_q       <= {5'b10000, win_line_i};
            ack_q      <= 1'b1;
            ack_line_q <= win_line_i;
            if (!aeoi_q)    isr_q[win_line_i] <= 1'b1;
            else if (rot_q) off_q <= win_line_i + 1'b1;
          end else begin
            rd_q <= 8'h00;
          end
        end else if (addr_i) begin
          rd_q <= imr_q;
        end else begin
          rd_q <= rsel_q ? isr_q : pend_i;
        end
      end
    end
  end

  assign rd_data_o   = rd_q;
  assign isr_o       = isr_q;
  assign imr_o       = imr_q;
  assign offset_o    = off_q;
  assign vec_base_o  = {base_q, 3'b000};
  assign aeoi_o      = aeoi_q;
  assign rot_aeoi_o  = rot_q;
  assign spec_mask_o = smm_q;
  assign nested_o    = nest_q;
  assign ack_o       = ack_q;
  assign ack_line_o  = ack_line_q;
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       rd_en_i,
  input logic       win_valid_i,
  input logic [2:0] win_line_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] isr_o,
  input logic [7:0] imr_o,
  input logic [2:0] offset_o,
  input logic       ack_o,
  input logic [1:0] init_st,
  input logic       poll_q
);
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !addr_i && wr_data_i[4] |=> isr_o == 8'h00 && imr_o == 8'h00 && offset_o == 3'd0); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i && init_st == 2'd0 |=> imr_o == $past(wr_data_i)); // R3
  AST_MASK_HOLD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i && init_st != 2'd0 |=> $stable(imr_o)); // R3
  AST_SPECIFIC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !addr_i && wr_data_i[7:3] == 5'b01100 |=> !isr_o[$past(wr_data_i[2:0])]); // R8
  AST_SET_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !addr_i && wr_data_i[7:3] == 5'b11000 |=> offset_o == $past(wr_data_i[2:0]) + 3'd1); // R8
  AST_NOP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !addr_i && wr_data_i[7:3] == 5'b01000 |=> $stable(isr_o) && $stable(offset_o)); // R8
  AST_POLL_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !wr_en_i && poll_q && win_valid_i |=> ack_o && rd_data_o == {5'b10000, $past(win_line_i)}); // R9
  AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !wr_en_i && poll_q && !win_valid_i |=> !ack_o && rd_data_o == 8'h00); // R9
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk u_chk (.*);

// File: tb/pic_cmd_decoder_bench.sv
module pic_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, win_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0, pend_i = '0;
  logic [2:0] win_line_i = '0;
  logic [7:0] rd_data_o, isr_o, imr_o, vec_base_o;
  logic [2:0] offset_o, ack_line_o;
  logic       aeoi_o, rot_aeoi_o, spec_mask_o, nested_o, ack_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_isr, m_imr, m_base, m_rd;
  logic [2:0] m_off, m_ackl;
  logic [1:0] m_st;
  logic m_i4, m_sgl, m_aeoi, m_rot, m_rsel, m_poll, m_smm, m_nest, m_ack;

  always #10 clk = ~clk;

  pic_cmd_decoder u_pic_cmd_decoder (.*);

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_isr = 0; m_imr = 0; m_base = 0; m_rd = 0; m_off = 0; m_ackl = 0; m_st = 0;
    m_i4 = 0; m_sgl = 0; m_aeoi = 0; m_rot = 0; m_rsel = 0; m_poll = 0; m_smm = 0;
    m_nest = 0; m_ack = 0;
  endtask

  task automatic model_step(logic a, logic w, logic [7:0] d, logic r, logic [7:0] pend,
                            logic wv, logic [2:0] wl);
    m_ack = 0;
    if (w && !a && d[4]) begin
      m_isr = 0; m_imr = 0; m_base = 0; m_off = 0; m_rsel = 0; m_poll = 0; m_smm = 0;
      m_aeoi = 0; m_rot = 0; m_nest = 0; m_st = 1; m_i4 = d[0]; m_sgl = d[1];
    end else if (w && !a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (w && !a) begin
      case (d[7:5])
        3'd0: m_rot = 0;
        3'd4: m_rot = 1;
        3'd1, 3'd5: begin
          for (int p = 0; p < 8; p++) begin
            logic [2:0] k;
            k = m_off + 3'(p);
            if (m_isr[k]) begin
              m_isr[k] = 0;
              if (d[7]) m_off = k + 3'd1;
              break;
            end
          end
        end
        3'd3: m_isr[d[2:0]] = 0;
        3'd6: m_off = d[2:0] + 3'd1;
        3'd7: begin m_isr[d[2:0]] = 0; m_off = d[2:0] + 3'd1; end
        default: ;
      endcase
    end else if (w) begin
      case (m_st)
        2'd0: m_imr = d;
        2'd1: begin m_base = d & 8'hF8; m_st = !m_sgl ? 2'd2 : (m_i4 ? 2'd3 : 2'd0); end
        2'd2: m_st = m_i4 ? 2'd3 : 2'd0;
        default: begin m_aeoi = d[1]; m_nest = d[4]; m_st = 0; end
      endcase
    end else if (r) begin
      if (m_poll) begin
        m_poll = 0;
        if (wv) begin
          m_rd = 8'h80 | {5'd0, wl}; m_ack = 1; m_ackl = wl;
          if (!m_aeoi) m_isr[wl] = 1;
          else if (m_rot) m_off = wl + 3'd1;
        end else m_rd = 0;
      end else m_rd = a ? m_imr : (m_rsel ? m_isr : pend);
    end
  endtask

  task automatic compare(string req);
    check(req, "isr", isr_o, m_isr);
    check(req, "imr", imr_o, m_imr);
    check(req, "offset", {5'd0, offset_o}, {5'd0, m_off});
    check(req, "base", vec_base_o, m_base);
    check(req, "flags", {4'd0, aeoi_o, rot_aeoi_o, spec_mask_o, nested_o},
          {4'd0, m_aeoi, m_rot, m_smm, m_nest});
    check(req, "rd_data", rd_data_o, m_rd);
    check(req, "ack", {4'd0, ack_o, ack_line_o}, {4'd0, m_ack, m_ack ? m_ackl : ack_line_o});
  endtask

  task automatic step(string req, logic a, logic w, logic [7:0] d, logic r,
                      logic [7:0] pend, logic wv, logic [2:0] wl);
    addr_i = a; wr_en_i = w; wr_data_i = d; rd_en_i = r; pend_i = pend;
    win_valid_i = wv; win_line_i = wl;
    model_step(a, w, d, r, pend, wv, wl);
    @(negedge clk);
    compare(req);
  endtask

  task automatic wr(string req, logic a, logic [7:0] d);
    step(req, a, 1'b1, d, 1'b0, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic rd(string req, logic a, logic [7:0] pend, logic wv, logic [2:0] wl);
    step(req, a, 1'b0, 8'h00, 1'b1, pend, wv, wl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R12");
    rst_n = 1'b1;
    @(negedge clk);

    // cascaded init with fourth word: base 0x47 -> 0x40, aeoi + nested
    wr("R1", 1'b0, 8'h11);
    wr("R2", 1'b1, 8'h47);
    wr("R3", 1'b1, 8'hAA);
    wr("R11", 1'b1, 8'h12);
    wr("R3", 1'b1, 8'h5A);
    rd("R12", 1'b1, 8'h00, 1'b0, 3'd0);
    // rotate on auto EOI, poll: offset moves, no in-service bit
    wr("R6", 1'b0, 8'h80);
    wr("R4", 1'b0, 8'h0C);
    rd("R10", 1'b0, 8'h00, 1'b1, 3'd5);
    wr("R4", 1'b0, 8'h0C);
    rd("R9", 1'b0, 8'h00, 1'b0, 3'd0);
    // single mode without fourth word: next address-1 write is the mask
    wr("R1", 1'b0, 8'h12);
    wr("R2", 1'b1, 8'hFF);
    wr("R3", 1'b1, 8'h3C);
    // single mode with fourth word
    wr("R1", 1'b0, 8'h13);
    wr("R2", 1'b1, 8'h20);
    wr("R11", 1'b1, 8'h00);
    // fill in-service via polls, then end interrupts
    for (int i = 0; i < 4; i++) begin
      wr("R4", 1'b0, 8'h0C);
      rd("R10", 1'b0, 8'h00, 1'b1, 3'(i * 2 + 1));
    end
    wr("R4", 1'b0, 8'h0B);
    rd("R12", 1'b0, 8'h55, 1'b0, 3'd0);
    wr("R8", 1'b0, 8'hC5);
    wr("R7", 1'b0, 8'hA0);
    wr("R7", 1'b0, 8'h20);
    wr("R8", 1'b0, 8'h40);
    wr("R8", 1'b0, 8'h65);
    wr("R8", 1'b0, 8'hE3);
    wr("R5", 1'b0, 8'h68);
    wr("R5", 1'b0, 8'h28);
    wr("R5", 1'b0, 8'h48);
    wr("R4", 1'b0, 8'h0A);
    rd("R12", 1'b0, 8'h96, 1'b0, 3'd0);

    for (int n = 0; n < 4000; n++) begin
      int unsigned sel;
      logic [7:0] d;
      sel = $urandom % 16;
      d = 8'($urandom);
      case (sel)
        0: wr("R1", 1'b0, (d & 8'hE7) | 8'h10);
        1, 2, 3: wr("R2", 1'b1, d);
        4, 5, 6: wr("R7", 1'b0, d & 8'hE7);
        7: wr("R8", 1'b0, d & 8'hE7);
        8, 9: wr("R4", 1'b0, (d & 8'hEF) | 8'h0C);
        10: wr("R5", 1'b0, (d & 8'hEF) | 8'h08);
        11, 12, 13, 14: rd("R9", 1'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
        default: step("R12", 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule